// File: doc/BRIEF.md
# Instruction Cache Control Unit

This block owns the three cache-control bits of a 16-bit status word (freeze, enable and flush). It drives a small two-way set-associative instruction cache from those bits. It keeps the valid bit, tag and data word for every line of both ways, and a per-set least-recently-used marker. Fetches that hit return in one cycle. Fetches that miss go out on an external memory port, and the returned word is written into the victim way.

When the enable bit is clear, the arrays are not consulted at all. Every fetch is passed to external memory, and nothing is written back into the cache. Writing 1 to the flush bit starts a sequential sweep that clears the valid bits of one set (both ways) per clock. The flush bit reads 1 until the sweep has finished and then drops by itself. While the sweep runs, the fetch port is stalled and no line fill takes place.

Software is expected to set up the cache while it is disabled and to enable it afterwards. The freeze bit is only stored and read back.

Top module: `icache_ctrl`

## Requirements
- R1: After reset the status word reads 0x0000, `fetchValid` and `memReq` are 0 and `fetchReady` is 1.
- R2: Status bit 15 (freeze) and bit 14 (enable) read back the last value written. Bits 12..0 always read 0.
- R3: With enable = 0, every accepted fetch raises `memReq` for one cycle, in the cycle after acceptance, with `memAddr` equal to the fetch address. The word from memory is returned, and the arrays are left unchanged, so the first fetch of that address after enabling still misses.
- R4: With enable = 1, a fetch that hits raises `fetchValid` in the cycle after acceptance, with the stored word and no `memReq`.
- R5: With enable = 1, a miss requests memory and fills a way of set `addr[2:0]` with tag `addr[11:3]`. The filled way is way 0 if it is invalid, else way 1 if it is invalid, else the least-recently-used way. A hit or a fill marks the other way as least recently used.
- R6: After a write with bit 13 = 1, bit 13 reads 1 for exactly SETS cycles, starting in the cycle after the write, and then reads 0. Every line is then invalid.
- R7: During a flush, writing bit 13 as 0 does not abort the flush, and writing it as 1 does not restart it. The total duration stays SETS cycles.
- R8: `fetchReady` is 0 while a flush runs. A memory response that arrives during a flush is returned to the fetch port but is not filled into the cache.
- R9: `fetchReady` is 0 from the cycle after a miss is accepted until the cycle after the memory response. `fetchValid` rises in the cycle after `memValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srWrEn | input | 1 | Status word write strobe |
| srWrData | input | 16 | Status word write value |
| srRdData | output | 16 | Status word read value |
| fetchReq | input | 1 | Fetch request, accepted when `fetchReady` is 1 |
| fetchAddr | input | ADDR_W | Fetch word address |
| fetchReady | output | 1 | Block can accept a fetch |
| fetchValid | output | 1 | One-cycle pulse: `fetchData` is valid |
| fetchData | output | DATA_W | Fetched instruction word |
| memReq | output | 1 | One-cycle external memory read request |
| memAddr | output | ADDR_W | External memory read address |
| memValid | input | 1 | External memory read data valid |
| memData | input | DATA_W | External memory read data |

## Verification
A hit answers in the cycle after the accepting edge. A miss or bypass shows `memReq` in that same cycle and answers in the cycle after `memValid`. A status write is visible in the cycle after its edge, and the flush bit stays high for SETS sampled cycles. The bench drives at falling edges and samples each result exactly one falling edge after the rising edge that produces it. A reference model of valid bits, tags and LRU state predicts hit or miss for every fetch, and the bench checks that prediction against whether `memReq` appears.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int SR_W   = 16;
  localparam int SR_FRZ = 15;
  localparam int SR_EN  = 14;
  localparam int SR_CLR = 13;

  typedef struct packed {
    logic latchAddr;
    logic touch;
    logic loadHit;
    logic loadMem;
    logic fill;
    logic clear;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_MWAIT = 2'd2
  } ctlState_t;
endpackage

// File: rtl/icache_ctl.sv
module icache_ctl
  import icache_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srWrEn,
  input  logic [SR_W-1:0]  srWrData,
  output logic [SR_W-1:0]  srRdData,
  input  logic             fetchReq,
  output logic             fetchReady,
  output logic             fetchValid,
  input  logic             hit,
  output logic             memReq,
  input  logic             memValid,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] clrIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SETS - 1);

  ctlState_t state;
  logic frzBit, enBit, flushBusy, bypassQ;
  logic accept, hitNow, memDone;

  assign fetchReady = (state == ST_IDLE) && !flushBusy;
  assign accept     = fetchReq && fetchReady;
  assign hitNow     = accept && enBit && hit;
  assign memDone    = (state == ST_MWAIT) && memValid;
  assign memReq     = (state == ST_MREQ);
  assign srRdData   = {frzBit, enBit, flushBusy, 13'b0};

  always_comb begin
    strobe           = '0;
    strobe.latchAddr = accept;
    strobe.touch     = hitNow;
    strobe.loadHit   = hitNow;
    strobe.loadMem   = memDone;
    strobe.fill      = memDone && !bypassQ && !flushBusy;
    strobe.clear     = flushBusy;
  end

  // status bits and flush sweep
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frzBit    <= 1'b0;
      enBit     <= 1'b0;
      flushBusy <= 1'b0;
      clrIdx    <= '0;
    end else begin
      if (srWrEn) begin
        frzBit <= srWrData[SR_FRZ];
        enBit  <= srWrData[SR_EN];
      end
      if (flushBusy) begin
        clrIdx <= clrIdx + 1'b1;
        if (clrIdx == LAST_IDX) flushBusy <= 1'b0;
      end else if (srWrEn && srWrData[SR_CLR]) begin
        flushBusy <= 1'b1;
        clrIdx    <= '0;
      end
    end
  end

  // fetch sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bypassQ    <= 1'b0;
      fetchValid <= 1'b0;
    end else begin
      fetchValid <= hitNow || memDone;
      unique case (state)
        ST_IDLE: if (accept && !hitNow) begin
          state   <= ST_MREQ;
          bypassQ <= !enBit;
        end
        ST_MREQ:  state <= ST_MWAIT;
        ST_MWAIT: if (memValid) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  p_flush_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flushBusy) |-> $past(clrIdx) == LAST_IDX);
  p_stall_in_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    flushBusy |-> !fetchReady);
  p_no_fill_in_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fill |-> !flushBusy);
  p_bypass_to_mem_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !enBit) |=> memReq);
  p_busy_until_resp_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !fetchReady);
endmodule

// File: rtl/icache_dp.sv
module icache_dp
  import icache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int SETS   = 8,
  parameter int IDX_W  = $clog2(SETS),
  parameter int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [IDX_W-1:0]  clrIdx,
  input  logic [DATA_W-1:0] memData,
  output logic              hit,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] fetchData
);
  localparam int WAYS = 2;

  logic [WAYS-1:0]   valid   [SETS];
  logic [TAG_W-1:0]  tagMem  [WAYS][SETS];
  logic [DATA_W-1:0] dataMem [WAYS][SETS];
  logic              lru     [SETS];

  logic [IDX_W-1:0]  lkIdx, fIdx;
  logic [TAG_W-1:0]  lkTag, fTag;
  logic [WAYS-1:0]   wayHit;
  logic              hitWay, victim;
  logic [DATA_W-1:0] hitData;

  assign lkIdx = fetchAddr[IDX_W-1:0];
  assign lkTag = fetchAddr[ADDR_W-1:IDX_W];
  assign fIdx  = reqAddr[IDX_W-1:0];
  assign fTag  = reqAddr[ADDR_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayHit[w] = valid[lkIdx][w] && (tagMem[w][lkIdx] == lkTag);
  end

  assign hit     = |wayHit;
  assign hitWay  = wayHit[1];
  assign hitData = dataMem[hitWay][lkIdx];
  assign victim  = !valid[fIdx][0] ? 1'b0 :
                   !valid[fIdx][1] ? 1'b1 : lru[fIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        valid[s] <= '0;
        lru[s]   <= 1'b0;
      end
    end else begin
      if (strobe.clear) valid[clrIdx] <= '0;
      if (strobe.fill) begin
        valid[fIdx][victim] <= 1'b1;
        lru[fIdx]           <= !victim;
      end
      if (strobe.touch) lru[lkIdx] <= !hitWay;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fill) begin
      tagMem[victim][fIdx]  <= fTag;
      dataMem[victim][fIdx] <= memData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr   <= '0;
      fetchData <= '0;
    end else begin
      if (strobe.latchAddr) reqAddr <= fetchAddr;
      if (strobe.loadHit)       fetchData <= hitData;
      else if (strobe.loadMem)  fetchData <= memData;
    end
  end

  p_single_way_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wayHit));
  p_touch_on_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.touch |-> hit);
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int SETS   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srWrEn,
  input  logic [15:0]       srWrData,
  output logic [15:0]       srRdData,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchReady,
  output logic              fetchValid,
  output logic [DATA_W-1:0] fetchData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [DATA_W-1:0] memData
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  dpStrobe_t        strobe;
  logic             hit;
  logic [IDX_W-1:0] clrIdx;

  icache_ctl #(.SETS(SETS), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .srWrEn(srWrEn), .srWrData(srWrData), .srRdData(srRdData),
    .fetchReq(fetchReq), .fetchReady(fetchReady), .fetchValid(fetchValid),
    .hit(hit), .memReq(memReq), .memValid(memValid),
    .strobe(strobe), .clrIdx(clrIdx)
  );

  icache_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS),
              .IDX_W(IDX_W), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fetchAddr(fetchAddr), .clrIdx(clrIdx), .memData(memData),
    .hit(hit), .reqAddr(memAddr), .fetchData(fetchData)
  );
endmodule

// File: tb/tb_icache_ctrl.sv
module tb_icache_ctrl;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int SETS   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic srWrEn = 1'b0;
  logic [15:0] srWrData = '0;
  logic [15:0] srRdData;
  logic fetchReq = 1'b0;
  logic [ADDR_W-1:0] fetchAddr = '0;
  logic fetchReady, fetchValid, memReq;
  logic [DATA_W-1:0] fetchData;
  logic [ADDR_W-1:0] memAddr;
  logic memValid = 1'b0;
  logic [DATA_W-1:0] memData = '0;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  bit curEn = 1'b0;
  bit curFrz = 1'b0;

  logic [8:0] mTag [SETS][2];
  bit         mVld [SETS][2];
  bit         mLru [SETS];

  always #4 clk = ~clk;

  icache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) dut (
    .clk(clk), .rstN(rstN), .srWrEn(srWrEn), .srWrData(srWrData),
    .srRdData(srRdData), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchReady(fetchReady), .fetchValid(fetchValid), .fetchData(fetchData),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData)
  );

  function automatic logic [15:0] memWord(logic [ADDR_W-1:0] a);
    return (16'(a) * 16'd40503) ^ 16'h1d2b;
  endfunction

  function automatic int mLook(logic [ADDR_W-1:0] a);
    for (int w = 0; w < 2; w++)
      if (mVld[a[2:0]][w] && mTag[a[2:0]][w] == a[11:3]) return w;
    return -1;
  endfunction

  task automatic mFill(logic [ADDR_W-1:0] a);
    int v;
    v = !mVld[a[2:0]][0] ? 0 : !mVld[a[2:0]][1] ? 1 : int'(mLru[a[2:0]]);
    mVld[a[2:0]][v] = 1'b1;
    mTag[a[2:0]][v] = a[11:3];
    mLru[a[2:0]] = (v == 0);
  endtask

  task automatic mClear();
    for (int s = 0; s < SETS; s++) begin
      mVld[s][0] = 1'b0;
      mVld[s][1] = 1'b0;
    end
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeSr(logic [15:0] d);
    srWrEn = 1'b1;
    srWrData = d;
    @(negedge clk);
    srWrEn = 1'b0;
  endtask

  task automatic waitFlush();
    while (srRdData[13]) @(negedge clk);
  endtask

  task automatic doFetch(logic [ADDR_W-1:0] a, bit flushMid);
    int w;
    int lat;
    while (!fetchReady) @(negedge clk);
    w = curEn ? mLook(a) : -1;
    fetchReq = 1'b1;
    fetchAddr = a;
    @(negedge clk);
    fetchReq = 1'b0;
    if (w >= 0) begin
      check(fetchValid && !memReq, "R4 hit timing", {fetchValid, memReq}, 2'b10);
      check(fetchData == memWord(a), "R4 hit data", fetchData, memWord(a));
      mLru[a[2:0]] = (w == 0);
    end else begin
      check(memReq && !fetchValid, curEn ? "R5 miss request" : "R3 bypass request",
            {memReq, fetchValid}, 2'b10);
      check(memAddr == a, "R3 memAddr", memAddr, a);
      check(!fetchReady, "R9 ready low", fetchReady, 0);
      if (flushMid) writeSr({curFrz, curEn, 1'b1, 13'b0});
      else @(negedge clk);
      lat = $urandom_range(0, 3);
      repeat (lat) @(negedge clk);
      check(!fetchValid, "R9 no early valid", fetchValid, 0);
      memValid = 1'b1;
      memData = memWord(a);
      @(negedge clk);
      memValid = 1'b0;
      check(fetchValid && fetchData == memWord(a), "R9 response",
            fetchData, memWord(a));
      if (flushMid) begin
        mClear();
        waitFlush();
      end else if (curEn) begin
        mFill(a);
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'h5eed));
    mClear();
    for (int s = 0; s < SETS; s++) mLru[s] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1
    check(srRdData == 16'h0000, "R1 status", srRdData, 0);
    check(!fetchValid && !memReq && fetchReady, "R1 ports",
          {fetchValid, memReq, fetchReady}, 3'b001);

    // R2
    writeSr(16'h8000);
    check(srRdData == 16'h8000, "R2 freeze", srRdData, 16'h8000);
    writeSr(16'h5fff);
    check(srRdData == 16'h4000, "R2 enable, low bits zero", srRdData, 16'h4000);
    writeSr(16'hffff);
    check(srRdData == 16'he000, "R2 all written", srRdData, 16'he000);
    waitFlush();
    check(srRdData == 16'hc000, "R2 after flush", srRdData, 16'hc000);
    writeSr(16'h0000);
    curEn = 1'b0;
    curFrz = 1'b0;

    // R3 bypass: both fetches go to memory, nothing cached
    doFetch(12'h123, 1'b0);
    doFetch(12'h123, 1'b0);
    writeSr(16'h4000);
    curEn = 1'b1;
    doFetch(12'h123, 1'b0);
    doFetch(12'h123, 1'b0);

    // R5 LRU: set 1 with three tags
    doFetch(12'h009, 1'b0);
    doFetch(12'h011, 1'b0);
    doFetch(12'h009, 1'b0);
    doFetch(12'h019, 1'b0);
    doFetch(12'h009, 1'b0);
    doFetch(12'h011, 1'b0);
    check(mLook(12'h019) < 0, "R5 victim model", 0, 0);

    // R6 flush length and invalidation
    writeSr({curFrz, curEn, 1'b1, 13'b0});
    cnt = 0;
    while (srRdData[13] && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == SETS, "R6 flush length", cnt, SETS);
    mClear();
    doFetch(12'h009, 1'b0);

    // R7 and R8: writes during flush, ready held low
    writeSr({curFrz, curEn, 1'b1, 13'b0});
    check(!fetchReady, "R8 stall in flush", fetchReady, 0);
    cnt = 0;
    while (srRdData[13] && cnt < 100) begin
      cnt++;
      srWrEn = (cnt == 3 || cnt == 5);
      srWrData = {curFrz, curEn, cnt == 5, 13'b0};
      @(negedge clk);
    end
    srWrEn = 1'b0;
    check(cnt == SETS, "R7 no abort or restart", cnt, SETS);
    mClear();

    // R8 response during flush is not filled
    doFetch(12'h2a4, 1'b0);
    doFetch(12'h3b5, 1'b1);
    doFetch(12'h3b5, 1'b0);
    doFetch(12'h2a4, 1'b0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      if (i % 50 == 49) begin
        writeSr({curFrz, curEn, 1'b1, 13'b0});
        waitFlush();
        mClear();
      end
      doFetch(ADDR_W'($urandom_range(0, 31)), 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule